// File: doc/BRIEF.md
# LFSR-Addressed Coded Word Store

This block collects four 4-bit code fragments, joins them into one 16-bit word and writes that word into a 16-entry on-chip store. The block picks the entry itself. A free-running 16-bit linear feedback shift register (LFSR) steps once per write, and its low four bits give the write address. The full register value at the moment of the write is kept beside the word as a per-entry key. A 4-bit seed strobe reloads the register from a pseudo-random source, and the expansion used for the reload can never produce the all-zero lock-up state.

Reading is done by entry index. The stored word is XORed with the key captured for that entry. A decoded bit is released, together with a one-cycle valid pulse, only when the top bit of that XOR is 1. In every other case the read yields nothing. The encoders that produce the fragments sit outside this block.

Top module: `coded_word_store`

## Requirements
- R1: After synchronous active-low reset, dec_vld and dec_bit are 0, the LFSR holds 16'hACE1, and every entry reads as word 0 with key 0, so no read decodes until the entry is written again.
- R2: The stored word is {frag3, frag2, frag1, frag0}: frag3 fills bits 15:12 and frag0 fills bits 3:0.
- R3: A write (wr_stb=1) goes to the entry addressed by LFSR bits 3:0 as they stand in that cycle, and stores the word together with the full 16-bit LFSR value as that entry's key.
- R4: The LFSR uses x^16+x^14+x^13+x^11+1 and shifts left by one, taking in at bit 0 the XOR of bits 15, 13, 12 and 10. It steps once on every write and holds in every other cycle.
- R5: A seed load (seed_ld=1) sets the LFSR to {~seed, seed, ~seed, seed}, with seed in bits 3:0, which is never zero. A load takes precedence over the step when a write falls in the same cycle, and that write still uses the LFSR value from before the load.
- R6: A read (rd_stb=1) of entry rd_idx computes x = word XOR key. dec_vld is 1 in the next cycle if and only if x[15] is 1.
- R7: When dec_vld is 1, dec_bit equals x[0]. When dec_vld is 0, dec_bit is 0.
- R8: A read and a write to the same entry in the same cycle return the contents from before that write.
- R9: A later write to an entry replaces both its word and its key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| frag0 | input | 4 | Code fragment for word bits 3:0 |
| frag1 | input | 4 | Code fragment for word bits 7:4 |
| frag2 | input | 4 | Code fragment for word bits 11:8 |
| frag3 | input | 4 | Code fragment for word bits 15:12 |
| wr_stb | input | 1 | Store the joined word at the LFSR-chosen entry |
| rd_stb | input | 1 | Read and decode entry rd_idx |
| rd_idx | input | 4 | Entry to read |
| seed_ld | input | 1 | Reload the LFSR from seed |
| seed | input | 4 | Pseudo-random seed value |
| dec_bit | output | 1 | Decoded bit, valid with dec_vld |
| dec_vld | output | 1 | One-cycle pulse for each read that decodes |

## Verification
Two pairs of functions can fall in the same cycle, and the bench provokes each pair on purpose. For the seed reload and a write, the bench raises seed_ld and wr_stb together. It then reads back both the entry written under the old register value and the entry addressed by the freshly loaded value, and each must decode against its own key. For a read and a write to the same entry, the bench reseeds so that the write lands on an entry it has already filled and reads that entry in the same cycle. The decode must follow the earlier word. A second read must then follow the new word.

// File: rtl/csw_pkg.sv
// Shared constants and types for the coded word store.
// Assumes: the word width is a whole multiple of the seed width.
package csw_pkg;
    localparam int FRAG_W    = 4;
    localparam int N_FRAG    = 4;
    localparam int WORD_W    = FRAG_W * N_FRAG;
    localparam int ADDR_W    = 4;
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int SEED_W    = 4;
    localparam logic [WORD_W-1:0] TAP_MASK  = 16'hB400; // bits 15,13,12,10
    localparam logic [WORD_W-1:0] LFSR_INIT = 16'hACE1;

    typedef logic [WORD_W-1:0] word_t;

    // One stored entry: the coded word and the LFSR key captured with it.
    typedef struct packed {
        word_t word;
        word_t key;
    } entry_t;
endpackage

// File: rtl/csw_lfsr.sv
// Address/key generator: a Fibonacci LFSR that steps once per write and
// reloads from a short seed. The seed is spread as alternating true and
// inverted copies, so the loaded state can never be all zeros.
// Assumes: W is a multiple of 2*SW.
module csw_lfsr #(
    parameter int          W     = csw_pkg::WORD_W,
    parameter int          SW    = csw_pkg::SEED_W,
    parameter logic [W-1:0] TAPS = csw_pkg::TAP_MASK,
    parameter logic [W-1:0] INIT = csw_pkg::LFSR_INIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          load,
    input  logic [SW-1:0] seed,
    output logic [W-1:0]  state
);
    localparam int CHUNKS = W / SW;

    logic [W-1:0] seeded;
    logic         fb;

    // Spread the seed over the full width with alternating polarity.
    always_comb begin
        seeded = '0;
        for (int i = 0; i < CHUNKS; i++) begin
            seeded[i*SW +: SW] = (i % 2 == 0) ? seed : ~seed;
        end
    end

    // Feedback is the parity of the tapped bits.
    assign fb = ^(state & TAPS);

    // State update: reset, then seed reload, then step on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= INIT;
        end else if (load) begin
            state <= seeded;
        end else if (step) begin
            state <= {state[W-2:0], fb};
        end
    end

    p_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);
    p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> state[W-1:1] == $past(state[W-2:0]));
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(state));
    p_seed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (state[SW-1:0] == $past(seed)) && (state[2*SW-1:SW] == ~$past(seed)));
endmodule

// File: rtl/csw_bank.sv
// Entry store: holds a word and its capture key per entry. Writes land at
// the edge. Reads are combinational, so a same-cycle read sees the old entry.
// Assumes: one write port and one read port.
module csw_bank #(
    parameter int W  = csw_pkg::WORD_W,
    parameter int AW = csw_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  word_in,
    input  logic [W-1:0]  key_in,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  word_out,
    output logic [W-1:0]  key_out
);
    localparam int N = 1 << AW;

    logic [W-1:0] word_q [N];
    logic [W-1:0] key_q  [N];

    // Clear all entries on reset; otherwise store word and key on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                word_q[i] <= '0;
                key_q[i]  <= '0;
            end
        end else if (wr_en) begin
            word_q[wr_addr] <= word_in;
            key_q[wr_addr]  <= key_in;
        end
    end

    // Read path: the addressed entry, before any write at this edge.
    assign word_out = word_q[rd_addr];
    assign key_out  = key_q[rd_addr];

    p_key_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> key_q[$past(wr_addr)] == $past(key_in));
    p_word_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> word_q[$past(wr_addr)] == $past(word_in));
endmodule

// File: rtl/csw_decode.sv
// Gated decoder: XORs a stored word with its key. It releases bit 0 of the
// result with a one-cycle valid pulse only when the top bit is set.
// Assumes: word and key are stable in the cycle rd_stb is high.
module csw_decode #(
    parameter int W = csw_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_stb,
    input  logic [W-1:0] word,
    input  logic [W-1:0] key,
    output logic         dec_bit,
    output logic         dec_vld
);
    logic [W-1:0] mix;
    logic         pass;

    // Unmask the stored word and test its gate bit.
    assign mix  = word ^ key;
    assign pass = rd_stb && mix[W-1];

    // Register the decision; the bit is forced low when there is no decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_vld <= 1'b0;
            dec_bit <= 1'b0;
        end else begin
            dec_vld <= pass;
            dec_bit <= pass && mix[0];
        end
    end

    p_vld_needs_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |-> $past(rd_stb));
    p_bit_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_vld |-> !dec_bit);
endmodule

// File: rtl/coded_word_store.sv
// Top level: joins four fragments into one word and stores it with its
// LFSR key at the LFSR-chosen entry. Reads decode an entry by index.
// Assumes: fragments are valid in the cycle wr_stb is high.
module coded_word_store (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] frag0,
    input  logic [3:0] frag1,
    input  logic [3:0] frag2,
    input  logic [3:0] frag3,
    input  logic       wr_stb,
    input  logic       rd_stb,
    input  logic [3:0] rd_idx,
    input  logic       seed_ld,
    input  logic [3:0] seed,
    output logic       dec_bit,
    output logic       dec_vld
);
    import csw_pkg::*;

    logic [FRAG_W-1:0] frags [N_FRAG];
    word_t             joined;
    word_t             lfsr_q;
    word_t             rd_word;
    word_t             rd_key;

    // Present the fragment ports as an indexed array.
    assign frags[0] = frag0;
    assign frags[1] = frag1;
    assign frags[2] = frag2;
    assign frags[3] = frag3;

    // Join the fragments; fragment k fills slice k.
    for (genvar k = 0; k < N_FRAG; k++) begin : g_join
        assign joined[k*FRAG_W +: FRAG_W] = frags[k];
    end

    csw_lfsr #(
        .W(WORD_W), .SW(SEED_W), .TAPS(TAP_MASK), .INIT(LFSR_INIT)
    ) u_lfsr (
        .clk(clk), .rst_n(rst_n), .step(wr_stb), .load(seed_ld),
        .seed(seed), .state(lfsr_q)
    );

    csw_bank #(.W(WORD_W), .AW(ADDR_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_stb),
        .wr_addr(lfsr_q[ADDR_W-1:0]), .word_in(joined), .key_in(lfsr_q),
        .rd_addr(rd_idx), .word_out(rd_word), .key_out(rd_key)
    );

    csw_decode #(.W(WORD_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .word(rd_word),
        .key(rd_key), .dec_bit(dec_bit), .dec_vld(dec_vld)
    );
endmodule

// File: tb/coded_word_store_test.sv
`timescale 1ns/1ps
module coded_word_store_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] frag0 = '0, frag1 = '0, frag2 = '0, frag3 = '0;
    logic       wr_stb = 1'b0, rd_stb = 1'b0, seed_ld = 1'b0;
    logic [3:0] rd_idx = '0, seed = '0;
    logic       dec_bit, dec_vld;

    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    logic [15:0] model;          // expected LFSR value
    logic [15:0] exp_x [16];     // expected word XOR key per entry

    localparam logic [15:0] TARGETS [8] = '{
        16'h8001, 16'h8000, 16'h7FFF, 16'hFFFF,
        16'h214E, 16'hC3A5, 16'h0001, 16'h8F0E
    };

    always #2.5 clk = ~clk;

    coded_word_store uut (
        .clk(clk), .rst_n(rst_n), .frag0(frag0), .frag1(frag1),
        .frag2(frag2), .frag3(frag3), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .rd_idx(rd_idx), .seed_ld(seed_ld), .seed(seed),
        .dec_bit(dec_bit), .dec_vld(dec_vld)
    );

    function automatic logic [15:0] step_of(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic logic [15:0] spread(input logic [3:0] s);
        return {~s, s, ~s, s};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put_word(input logic [15:0] w);
        {frag3, frag2, frag1, frag0} = w;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model = 16'hACE1;
        for (int i = 0; i < 16; i++) exp_x[i] = '0;
    endtask

    // Write so that word XOR key equals target at the modelled address.
    task automatic write_target(input logic [15:0] target);
        @(negedge clk);
        put_word(model ^ target);
        wr_stb = 1'b1;
        exp_x[model[3:0]] = target;
        @(negedge clk);
        wr_stb = 1'b0;
        model = step_of(model);
    endtask

    task automatic load_seed(input logic [3:0] s);
        @(negedge clk);
        seed = s;
        seed_ld = 1'b1;
        @(negedge clk);
        seed_ld = 1'b0;
        model = spread(s);
    endtask

    // Read one entry and judge the decode against the expected XOR.
    task automatic read_check(input logic [3:0] idx, input string req);
        logic [15:0] x;
        x = exp_x[idx];
        @(negedge clk);
        rd_idx = idx;
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        check({req, " vld"}, {15'd0, dec_vld}, {15'd0, x[15]});
        check({req, " bit"}, {15'd0, dec_bit}, {15'd0, x[15] & x[0]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [3:0] a;
        logic [15:0] old_t;
        do_reset();
        // R1: reset state at the ports, and unwritten entries do not decode.
        @(negedge clk);
        check("R1 reset vld", {15'd0, dec_vld}, 16'd0);
        check("R1 reset bit", {15'd0, dec_bit}, 16'd0);
        read_check(4'd5, "R1 empty entry");

        // Table walk: R1 start value, R2 field order, R3 address/key, R4 stepping, R6/R7 gating.
        for (int i = 0; i < 8; i++) begin
            a = model[3:0];
            write_target(TARGETS[i]);
            read_check(a, "R6 R7 R2 R3 R4 table");
        end

        // R4: idle cycles hold the LFSR, so the next key is still the model.
        repeat (5) @(negedge clk);
        a = model[3:0];
        write_target(16'h8001);
        read_check(a, "R4 hold");

        // R5: seed load sets {~s,s,~s,s}; seed 0 gives F0F0, not zero.
        load_seed(4'h3);
        check("R5 spread", spread(4'h3), 16'hC3C3);
        write_target(16'h8001);
        read_check(4'h3, "R5 seed 3");
        load_seed(4'h0);
        write_target(16'h8000);
        read_check(4'h0, "R5 seed 0");

        // R5: load and write together; the write uses the old value, the load wins.
        load_seed(4'h5);
        @(negedge clk);
        put_word(model ^ 16'h8001);
        exp_x[model[3:0]] = 16'h8001;
        wr_stb = 1'b1;
        seed = 4'h9;
        seed_ld = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        seed_ld = 1'b0;
        model = spread(4'h9);
        write_target(16'hC000);
        read_check(4'h5, "R5 same-cycle old key");
        read_check(4'h9, "R5 same-cycle new seed");

        // R8: read and write to one entry together see the old contents; R9 replaces it.
        load_seed(4'hA);
        write_target(16'h8001);
        old_t = exp_x[4'hA];
        load_seed(4'hA);
        @(negedge clk);
        put_word(model ^ 16'h0000);
        wr_stb = 1'b1;
        rd_idx = 4'hA;
        rd_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        rd_stb = 1'b0;
        check("R8 old vld", {15'd0, dec_vld}, {15'd0, old_t[15]});
        check("R8 old bit", {15'd0, dec_bit}, {15'd0, old_t[15] & old_t[0]});
        exp_x[4'hA] = 16'h0000;
        model = step_of(model);
        read_check(4'hA, "R9 replaced");

        // R1: reset in mid-run clears entries and restarts the LFSR.
        do_reset();
        read_check(4'h3, "R1 cleared entry");
        write_target(16'h8001);
        read_check(4'h1, "R1 restart value");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule